// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block takes 24-bit write frames from a three-wire serial link and loads an 18-bit code into the data register of a digital-to-analog converter. The link has an active-low frame select, a serial clock and a data line. All three pins are brought into the system clock domain through two-flop synchronizers, and edges are detected there. For this to work, the system clock must run at least four times faster than the serial clock.

A falling edge of the frame select opens a frame. Data is taken on each falling serial clock edge, most significant bit first. When the 24th bit arrives, the frame is committed, and the data register loads in the same system cycle as a one-cycle update strobe. If the frame select rises before that point, the frame is dropped: the partial shift state is cleared and the register keeps its old value. Until the first valid frame arrives, the register holds a power-on code chosen by a parameter, either zero or midscale.

Top module: `dacrx_top`

## Requirements
- R1: Serial clock edges are ignored while no frame is open. A frame opens only on a falling edge of `frame_n`.
- R2: Inside an open frame, `sdata` is sampled on each falling edge of `sclk`, most significant bit first.
- R3: Of the 24 frame bits (bit 23 first), bits 19 down to 2 form the 18-bit code. Bits 23..20 and 1..0 have no effect on the output.
- R4: The 24th falling edge of a frame loads `dac_code`. `dac_update` is high for exactly the one system cycle in which the new code first appears.
- R5: If `frame_n` rises before the 24th falling edge, no update occurs and `dac_code` keeps its value. The next frame is decoded from a clean state.
- R6: After a frame completes, further `sclk` edges while `frame_n` stays low have no effect. Another frame needs `frame_n` to rise and then fall again.
- R7: While `rst` is high, and until the first valid frame, `dac_code` equals 0 when `POR_MID` is 0 and 0x20000 when `POR_MID` is 1. `dac_update` is low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| sdata | input | 1 | Serial data, read on falling `sclk` edges |
| frame_n | input | 1 | Active-low frame select |
| dac_code | output | 18 | DAC data register |
| dac_update | output | 1 | One-cycle strobe that marks a load of `dac_code` |

## Verification
Two conditions are hard to reach from the ports: a frame cut off one bit before completion, and a run of extra clocks after a completed frame with `frame_n` held low. In both cases the bench must show that nothing changed.

The stimulus aborts one frame after 10 bits and another after 23 bits. It sends a complete frame with six trailing clocks. It then sends a second block of 24 clocks without raising `frame_n` in between.

The scoreboard rejects any strobe it did not expect. After each abort, the register value is also compared against the last committed code.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;
    localparam int FRAME_BITS = 24;
    localparam int CODE_W     = 18;
    localparam int CODE_LSB   = 2;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_DONE  = 2'd2
    } fr_state_e;

    // events seen on the synchronized link, one system cycle wide
    typedef struct packed {
        logic sclk_fall;
        logic sel_fall;
        logic sel_rise;
        logic bit_val;
    } link_ev_t;

    function automatic logic [CODE_W-1:0] por_code(input bit mid);
        logic [CODE_W-1:0] v;
        v = '0;
        if (mid) v[CODE_W-1] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
    parameter int         WIDTH   = 3,
    parameter logic [2:0] RST_VAL = 3'b100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= RST_VAL[i];
                stage2[i] <= RST_VAL[i];
            end else begin
                stage1[i] <= d[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign q = stage2;
endmodule

// File: rtl/dacrx_edge.sv
module dacrx_edge
    import dacrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_s,
    input  logic     sdata_s,
    input  logic     sel_n_s,
    output link_ev_t ev
);
    logic sclk_d;
    logic sel_n_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            sel_n_d <= 1'b1;
        end else begin
            sclk_d  <= sclk_s;
            sel_n_d <= sel_n_s;
        end
    end

    always_comb begin
        ev.sclk_fall = sclk_d & ~sclk_s;
        ev.sel_fall  = sel_n_d & ~sel_n_s;
        ev.sel_rise  = ~sel_n_d & sel_n_s;
        ev.bit_val   = sdata_s;
    end
endmodule

// File: rtl/dacrx_frame.sv
module dacrx_frame
    import dacrx_pkg::*;
#(
    parameter int NBITS = FRAME_BITS,
    parameter int CW    = CODE_W,
    parameter int CLSB  = CODE_LSB
) (
    input  logic          clk,
    input  logic          rst,
    input  link_ev_t      ev,
    output logic          commit,
    output logic [CW-1:0] field
);
    localparam int SH_W  = CW + CLSB;
    localparam int CNT_W = $clog2(NBITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

    fr_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FR_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            unique case (state)
                FR_IDLE: begin
                    if (ev.sel_fall) begin
                        state <= FR_SHIFT;
                        cnt   <= '0;
                        shreg <= '0;
                    end
                end
                FR_SHIFT: begin
                    if (ev.sel_rise) begin
                        state <= FR_IDLE;
                        cnt   <= '0;
                        shreg <= '0;
                    end else if (ev.sclk_fall) begin
                        shreg <= {shreg[SH_W-2:0], ev.bit_val};
                        if (cnt == LAST) begin
                            cnt    <= '0;
                            commit <= 1'b1;
                            state  <= FR_DONE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                FR_DONE: begin
                    if (ev.sel_rise) state <= FR_IDLE;
                end
                default: state <= FR_IDLE;
            endcase
        end
    end

    assign field = shreg[CLSB +: CW];

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    assert_abort_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (state == FR_SHIFT && ev.sel_rise) |=> (state == FR_IDLE && cnt == '0 && !commit));

    assert_commit_from_shift_R4: assert property (@(posedge clk) disable iff (rst)
        commit |-> ($past(state) == FR_SHIFT && state == FR_DONE));

    assert_done_ignores_clk_R6: assert property (@(posedge clk) disable iff (rst)
        (state == FR_DONE && !ev.sel_rise) |=> (!commit && state == FR_DONE));

    assert_idle_no_commit_R1: assert property (@(posedge clk) disable iff (rst)
        (state == FR_IDLE) |=> !commit);
endmodule

// File: rtl/dacrx_top.sv
module dacrx_top
    import dacrx_pkg::*;
#(
    parameter int NBITS   = FRAME_BITS,
    parameter int CW      = CODE_W,
    parameter int CLSB    = CODE_LSB,
    parameter bit POR_MID = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk,
    input  logic          sdata,
    input  logic          frame_n,
    output logic [CW-1:0] dac_code,
    output logic          dac_update
);
    localparam logic [CW-1:0] POR_VAL = CW'(por_code(POR_MID));

    logic [2:0]    sync_q;
    link_ev_t      ev;
    logic          commit;
    logic [CW-1:0] field;

    dacrx_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({frame_n, sdata, sclk}),
        .q   (sync_q)
    );

    dacrx_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (sync_q[0]),
        .sdata_s (sync_q[1]),
        .sel_n_s (sync_q[2]),
        .ev      (ev)
    );

    dacrx_frame #(.NBITS(NBITS), .CW(CW), .CLSB(CLSB)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .commit (commit),
        .field  (field)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_code   <= POR_VAL;
            dac_update <= 1'b0;
        end else begin
            dac_update <= commit;
            if (commit) dac_code <= field;
        end
    end

    assert_hold_no_update_R5: assert property (@(posedge clk) disable iff (rst)
        !dac_update |-> $stable(dac_code));

    assert_pulse_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        dac_update |=> !dac_update);

    assert_reset_value_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dac_code == POR_VAL && !dac_update));
endmodule

// File: tb/dacrx_top_tb_top.sv
`timescale 1ns/1ps
module dacrx_top_tb_top;
    localparam int HALF = 4;
    localparam logic [17:0] MID = 18'h20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic        frame_n = 1'b1;
    logic [17:0] dac_code;
    logic        dac_update;

    int tests = 0;
    int fails = 0;
    int updates = 0;
    logic [17:0] expq[$];
    logic [17:0] last_exp = MID;
    logic        prev_upd = 1'b0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    dacrx_top #(.POR_MID(1'b1)) dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .frame_n(frame_n),
        .dac_code(dac_code), .dac_update(dac_update)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // open: drop frame_n first; nbits clocks; close: raise frame_n afterwards
    task automatic send(input logic [23:0] w, input int nbits, input bit open,
                        input bit close, input bit expect_load);
        if (expect_load) begin
            expq.push_back(w[19:2]);
            last_exp = w[19:2];
        end
        if (open) begin
            frame_n = 1'b0;
            wait_clk(HALF);
        end
        for (int i = 0; i < nbits; i++) begin
            sclk  = 1'b1;
            sdata = w[23 - (i % 24)];
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
        end
        wait_clk(HALF);
        if (close) begin
            frame_n = 1'b1;
            wait_clk(2 * HALF);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (dac_update) begin
                updates++;
                if (prev_upd) check("R4 strobe width", 32'd2, 32'd1);
                if (expq.size() == 0) begin
                    check("R1/R5/R6 unexpected update", 32'(dac_code), 32'hFFFFFFFF);
                end else begin
                    check("R2/R3/R4 loaded code", 32'(dac_code), 32'(expq.pop_front()));
                end
            end
            prev_upd = dac_update;
        end else begin
            prev_upd = 1'b0;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        check("R7 reset code", 32'(dac_code), 32'(MID));
        check("R7 reset strobe", 32'(dac_update), 32'd0);
        rst = 1'b0;
        wait_clk(4);
        check("R7 default held", 32'(dac_code), 32'(MID));

        // R1: clocks with no frame open
        for (int i = 0; i < 30; i++) begin
            sclk = 1'b1; sdata = i[0]; wait_clk(HALF);
            sclk = 1'b0; wait_clk(HALF);
        end
        check("R1 idle clocks ignored", 32'(dac_code), 32'(MID));

        send({4'hF, 18'h3FFFF, 2'b11}, 24, 1, 1, 1);
        send({4'h0, 18'h00001, 2'b00}, 24, 1, 1, 1);
        send({4'hA, 18'h2AAAA, 2'b01}, 24, 1, 1, 1);  // R3 don't-care mix

        // R5: abort after 10 and after 23 bits
        send({4'h5, 18'h15555, 2'b10}, 10, 1, 1, 0);
        check("R5 abort at 10 keeps code", 32'(dac_code), 32'(last_exp));
        send({4'hF, 18'h00F0F, 2'b11}, 23, 1, 1, 0);
        check("R5 abort at 23 keeps code", 32'(dac_code), 32'(last_exp));
        send({4'h3, 18'h12345, 2'b10}, 24, 1, 1, 1);

        // R6: extra clocks after completion, then new clocks without reopening
        send({4'h0, 18'h0F0F0, 2'b00}, 30, 1, 0, 1);
        send({4'hF, 18'h3C3C3, 2'b11}, 24, 0, 1, 0);
        check("R6 no reopen keeps code", 32'(dac_code), 32'(last_exp));

        // R7: reset mid-run returns to default
        @(negedge clk); rst = 1'b1;
        wait_clk(3);
        check("R7 reset restores default", 32'(dac_code), 32'(MID));
        rst = 1'b0;
        last_exp = MID;
        wait_clk(4);
        send({4'h9, 18'h1FFFF, 2'b01}, 24, 1, 1, 1);

        wait_clk(10);
        check("R4 all expected loads seen", 32'(expq.size()), 32'd0);
        check("R4 update count", 32'(updates), 32'd6);
        check("R2 final code", 32'(dac_code), 32'h1FFFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule